// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After reset this block reads a small 3-wire serial configuration EEPROM by bit-banging its chip-select, clock and data-in pins. It issues one read frame per 16-bit word, walking the whole 64-word image in ascending address order. It adds the words into a running checksum. It also keeps the few fields that set up the adapter.

When the last word is in, the checksum is compared against a fixed magic value. If the image is accepted, the block presents the following:
- the adapter's own bus ID, together with a one-hot mask of that ID;
- a tagged-queue depth, formed as a power of two from a stored shift field;
- an active-negation enable.

If the image is rejected, the ID falls back to 7 and the other options keep their reset values. A one-cycle done pulse marks the end of the load. The outputs then stay frozen until the next reset.

Every pin state is held for a fixed number of system clocks, set by a parameter. The default stretches each phase to 160 µs at 50 MHz.

Top module: `eecfg_loader`

## Requirements
- R1: While reset is high and in the cycle after it, eep_cs, eep_sk and eep_di are low. The outputs are also at their reset values: own_id 7, id_mask 8'h80, tag_depth 0, act_neg 0, cfg_valid 0 and load_done 0.
- R2: One read frame is issued per word, for word addresses 0 to 63 in ascending order. The 8-bit command of each frame is 8'h80 plus the word address.
- R3: A frame opens with a start bit of 1, followed by the 8 command bits, most significant first. Each bit is sent as three phases: eep_di is set with eep_sk low, then eep_sk goes high, then eep_sk goes low. eep_di never changes while eep_sk is high, and eep_sk is never high while eep_cs is low.
- R4: Each high level of eep_sk lasts exactly PHASE_CYCLES clocks.
- R5: After the command, exactly 16 data clocks follow in each frame, with eep_di held low. Each data clock is one low phase and one high phase. eep_do is sampled on the last clock of the high phase, and the bits are assembled most significant first.
- R6: Before every frame, including the first, eep_cs is low for exactly PHASE_CYCLES clocks.
- R7: cfg_valid is 1 exactly when the sum of all 64 words, taken modulo 2^16, equals 16'h1234.
- R8: With a valid image, own_id is bits [2:0] of the low byte of word 32, and id_mask is 1 << own_id.
- R9: With a valid image, tag_depth is 2 << s, where s is the high byte of word 33. If s exceeds DEPTH_W-2, tag_depth saturates to 1 << (DEPTH_W-1).
- R10: With a valid image, act_neg is bit 3 of the high byte of word 32, which is bit 11 of the word.
- R11: With an invalid image, own_id is 7, id_mask is 8'h80, tag_depth is 0 and act_neg is 0.
- R12: load_done is high for exactly one clock, and the configuration outputs and cfg_valid take their final values in that same clock. From then until reset the outputs do not change and all three pins stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| eep_do | input | 1 | Serial data from the EEPROM |
| eep_cs | output | 1 | EEPROM chip select |
| eep_sk | output | 1 | EEPROM serial clock |
| eep_di | output | 1 | Serial data to the EEPROM |
| own_id | output | 3 | Adapter bus ID |
| id_mask | output | 8 | One-hot mask of own_id |
| tag_depth | output | DEPTH_W | Tagged-queue depth |
| act_neg | output | 1 | Active-negation enable |
| cfg_valid | output | 1 | Image checksum matched |
| load_done | output | 1 | One-cycle pulse at end of load |

## Verification
The assertions take for granted that eep_do is driven by a device that follows the frame rules. They also assume reset is held for at least one clock, and that nothing other than a reset restarts a load. The bench meets these conditions with a behavioural EEPROM model. The model decodes the frames seen on the pins and changes eep_do only on rising serial clocks, so the value is settled well before the loader samples it. Every load starts from a fresh reset.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

    localparam int              WORD_W     = 16;
    localparam int              N_WORDS    = 64;
    localparam int              ADDR_W     = $clog2(N_WORDS);
    localparam int              FRAME_BITS = 9;
    localparam logic [7:0]      READ_OP    = 8'h80;
    localparam logic [15:0]     IMG_MAGIC  = 16'h1234;
    // word holding the ID byte (low) and option byte (high)
    localparam logic [ADDR_W-1:0] HOST_WORD  = ADDR_W'(32);
    // word whose high byte is the queue-depth shift
    localparam logic [ADDR_W-1:0] QUEUE_WORD = ADDR_W'(33);
    localparam int              NEG_BIT    = 8 + 3;
    localparam logic [2:0]      DEFAULT_ID = 3'd7;

    typedef enum logic [2:0] {
        PH_GAP,
        PH_CMD_SET,
        PH_CMD_HI,
        PH_CMD_LO,
        PH_DAT_LO,
        PH_DAT_HI,
        PH_HALT
    } phase_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } pins_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              last;
    } word_t;

    function automatic logic [FRAME_BITS-1:0] read_frame(input logic [ADDR_W-1:0] a);
        return {1'b1, READ_OP | 8'(a)};
    endfunction

endpackage

// File: rtl/eecfg_phase_timer.sv
module eecfg_phase_timer #(
    parameter int PHASE_CYCLES = 8000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int            CW   = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= LAST;
        else if (cnt == '0)   cnt <= LAST;
        else                  cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/eecfg_serial_engine.sv
module eecfg_serial_engine
    import eecfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  eep_do,
    output pins_t pins,
    output word_t word,
    output logic  word_stb
);
    phase_e                 ph;
    logic [3:0]             bit_n;
    logic [ADDR_W-1:0]      addr;
    logic [ADDR_W-1:0]      cap_addr;
    logic [WORD_W-1:0]      shreg;
    logic [FRAME_BITS-1:0]  frame;

    assign frame = read_frame(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_GAP;
            bit_n    <= '0;
            addr     <= '0;
            cap_addr <= '0;
            shreg    <= '0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            if (tick) begin
                unique case (ph)
                    PH_GAP: begin
                        ph    <= PH_CMD_SET;
                        bit_n <= 4'(FRAME_BITS - 1);
                    end
                    PH_CMD_SET: ph <= PH_CMD_HI;
                    PH_CMD_HI:  ph <= PH_CMD_LO;
                    PH_CMD_LO: begin
                        if (bit_n == '0) begin
                            ph    <= PH_DAT_LO;
                            bit_n <= 4'(WORD_W - 1);
                        end else begin
                            ph    <= PH_CMD_SET;
                            bit_n <= bit_n - 1'b1;
                        end
                    end
                    PH_DAT_LO: ph <= PH_DAT_HI;
                    PH_DAT_HI: begin
                        shreg <= {shreg[WORD_W-2:0], eep_do};
                        if (bit_n == '0) begin
                            word_stb <= 1'b1;
                            cap_addr <= addr;
                            addr     <= addr + 1'b1;
                            ph       <= (addr == ADDR_W'(N_WORDS - 1)) ? PH_HALT : PH_GAP;
                        end else begin
                            bit_n <= bit_n - 1'b1;
                            ph    <= PH_DAT_LO;
                        end
                    end
                    PH_HALT: ph <= PH_HALT;
                    default: ph <= PH_HALT;
                endcase
            end
        end
    end

    always_comb begin
        pins.cs = (ph != PH_GAP) && (ph != PH_HALT);
        pins.sk = (ph == PH_CMD_HI) || (ph == PH_DAT_HI);
        pins.di = ((ph == PH_CMD_SET) || (ph == PH_CMD_HI) || (ph == PH_CMD_LO))
                  ? frame[bit_n] : 1'b0;
    end

    assign word.addr = cap_addr;
    assign word.data = shreg;
    assign word.last = (cap_addr == ADDR_W'(N_WORDS - 1));
endmodule

// File: rtl/eecfg_image_check.sv
module eecfg_image_check
    import eecfg_pkg::*;
#(
    parameter int DEPTH_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  word_t              word,
    input  logic               word_stb,
    output logic [2:0]         own_id,
    output logic [7:0]         id_mask,
    output logic [DEPTH_W-1:0] tag_depth,
    output logic               act_neg,
    output logic               cfg_valid,
    output logic               load_done
);
    localparam int MAX_SHIFT = DEPTH_W - 2;

    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] sum_next;
    logic [2:0]        id_raw;
    logic              neg_raw;
    logic [7:0]        shift_raw;

    function automatic logic [DEPTH_W-1:0] depth_of(input logic [7:0] s);
        if (int'(s) > MAX_SHIFT) return {1'b1, {(DEPTH_W-1){1'b0}}};
        else                     return DEPTH_W'(2) << s;
    endfunction

    assign sum_next = sum + word.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum       <= '0;
            id_raw    <= '0;
            neg_raw   <= 1'b0;
            shift_raw <= '0;
            own_id    <= DEFAULT_ID;
            id_mask   <= 8'b1 << DEFAULT_ID;
            tag_depth <= '0;
            act_neg   <= 1'b0;
            cfg_valid <= 1'b0;
            load_done <= 1'b0;
        end else begin
            load_done <= 1'b0;
            if (word_stb) begin
                sum <= sum_next;
                if (word.addr == HOST_WORD) begin
                    id_raw  <= word.data[2:0];
                    neg_raw <= word.data[NEG_BIT];
                end
                if (word.addr == QUEUE_WORD) shift_raw <= word.data[15:8];
                if (word.last) begin
                    load_done <= 1'b1;
                    if (sum_next == IMG_MAGIC) begin
                        cfg_valid <= 1'b1;
                        own_id    <= id_raw;
                        id_mask   <= 8'b1 << id_raw;
                        tag_depth <= depth_of(shift_raw);
                        act_neg   <= neg_raw;
                    end else begin
                        cfg_valid <= 1'b0;
                        own_id    <= DEFAULT_ID;
                        id_mask   <= 8'b1 << DEFAULT_ID;
                        tag_depth <= '0;
                        act_neg   <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/eecfg_loader.sv
module eecfg_loader
    import eecfg_pkg::*;
#(
    parameter int PHASE_CYCLES = 8000,
    parameter int DEPTH_W      = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               eep_do,
    output logic               eep_cs,
    output logic               eep_sk,
    output logic               eep_di,
    output logic [2:0]         own_id,
    output logic [7:0]         id_mask,
    output logic [DEPTH_W-1:0] tag_depth,
    output logic               act_neg,
    output logic               cfg_valid,
    output logic               load_done
);
    logic  tick;
    pins_t pins;
    word_t word;
    logic  word_stb;

    eecfg_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    eecfg_serial_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .eep_do   (eep_do),
        .pins     (pins),
        .word     (word),
        .word_stb (word_stb)
    );

    eecfg_image_check #(.DEPTH_W(DEPTH_W)) u_image (
        .clk       (clk),
        .rst       (rst),
        .word      (word),
        .word_stb  (word_stb),
        .own_id    (own_id),
        .id_mask   (id_mask),
        .tag_depth (tag_depth),
        .act_neg   (act_neg),
        .cfg_valid (cfg_valid),
        .load_done (load_done)
    );

    assign eep_cs = pins.cs;
    assign eep_sk = pins.sk;
    assign eep_di = pins.di;
endmodule

// File: rtl/eecfg_loader_chk.sv
module eecfg_loader_chk #(
    parameter int DEPTH_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               eep_cs,
    input logic               eep_sk,
    input logic               eep_di,
    input logic [2:0]         own_id,
    input logic [7:0]         id_mask,
    input logic [DEPTH_W-1:0] tag_depth,
    input logic               act_neg,
    input logic               cfg_valid,
    input logic               load_done
);
    logic finished;

    always_ff @(posedge clk) begin
        if (rst)            finished <= 1'b0;
        else if (load_done) finished <= 1'b1;
    end

    // R3
    sk_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        eep_sk |-> eep_cs);

    // R3
    di_steady_chk: assert property (@(posedge clk) disable iff (rst)
        eep_sk |-> $stable(eep_di));

    // R8
    mask_matches_id_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(id_mask) && id_mask[own_id]);

    // R9
    depth_pow2_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |-> ($onehot(tag_depth) && !tag_depth[0]));

    // R11
    invalid_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |-> (own_id == 3'd7 && tag_depth == '0 && !act_neg));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_done |=> !load_done);

    // R12
    frozen_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        finished |-> ($stable(own_id) && $stable(tag_depth) && $stable(act_neg)
                      && $stable(cfg_valid) && !eep_cs && !eep_sk && !load_done));
endmodule

bind eecfg_loader eecfg_loader_chk #(.DEPTH_W(DEPTH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .eep_cs    (eep_cs),
    .eep_sk    (eep_sk),
    .eep_di    (eep_di),
    .own_id    (own_id),
    .id_mask   (id_mask),
    .tag_depth (tag_depth),
    .act_neg   (act_neg),
    .cfg_valid (cfg_valid),
    .load_done (load_done)
);

// File: tb/eecfg_loader_bench.sv
module eecfg_loader_bench;
    localparam int PHASE   = 2;
    localparam int DW      = 16;
    localparam int N_LOADS = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          eep_do = 1'b0;
    logic          eep_cs, eep_sk, eep_di;
    logic [2:0]    own_id;
    logic [7:0]    id_mask;
    logic [DW-1:0] tag_depth;
    logic          act_neg, cfg_valid, load_done;

    int vectors = 0;
    int misses  = 0;

    logic [15:0] mem [64];

    // model and monitor state
    int   edge_n, exp_addr, cmd_err, frame_err, di_err, sk_err, gap_err;
    int   sk_len, cs_low_len, done_cnt;
    logic [8:0] cmd_sh;
    logic cs_q, sk_q, di_q;

    always #10 clk = ~clk;

    eecfg_loader #(.PHASE_CYCLES(PHASE), .DEPTH_W(DW)) u_eecfg_loader (
        .clk(clk), .rst(rst), .eep_do(eep_do),
        .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_di(eep_di),
        .own_id(own_id), .id_mask(id_mask), .tag_depth(tag_depth),
        .act_neg(act_neg), .cfg_valid(cfg_valid), .load_done(load_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // EEPROM model plus pin monitor, all at the falling clock edge
    always @(negedge clk) begin
        if (rst) begin
            edge_n = 0; exp_addr = 0; cmd_err = 0; frame_err = 0; di_err = 0;
            sk_err = 0; gap_err = 0; sk_len = 0; cs_low_len = 0; done_cnt = 0;
            cmd_sh = '0; cs_q = 1'b0; sk_q = 1'b0; di_q = 1'b0; eep_do <= 1'b0;
        end else begin
            if (load_done) done_cnt++;
            if (eep_cs && !cs_q) begin
                if (cs_low_len != PHASE) gap_err++;
                edge_n = 0;
                cmd_sh = '0;
            end
            if (!eep_cs && cs_q && edge_n != 25) frame_err++;
            cs_low_len = eep_cs ? 0 : cs_low_len + 1;
            if (eep_sk && !eep_cs) sk_err++;
            if (eep_sk && sk_q && eep_di != di_q) di_err++;
            if (eep_sk) sk_len++;
            if (!eep_sk && sk_q) begin
                if (sk_len != PHASE) sk_err++;
                sk_len = 0;
            end
            if (eep_sk && !sk_q) begin
                edge_n++;
                if (edge_n <= 9) begin
                    cmd_sh = {cmd_sh[7:0], eep_di};
                    if (edge_n == 9) begin
                        if (exp_addr > 63 || cmd_sh != {1'b1, 8'h80 + 8'(exp_addr)}) cmd_err++;
                        exp_addr++;
                    end
                end else if (edge_n <= 25) begin
                    if (eep_di) frame_err++;
                    eep_do <= mem[(exp_addr - 1) & 63][25 - edge_n];
                end else frame_err++;
            end
            cs_q = eep_cs; sk_q = eep_sk; di_q = eep_di;
        end
    end

    function automatic int depth_exp(input int s);
        return (s > DW - 2) ? (1 << (DW - 1)) : (2 << s);
    endfunction

    initial begin
        repeat (195000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual hung expected load_done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int ld = 0; ld < N_LOADS; ld++) begin
            logic [7:0]  id_b, mode_b, tag_b;
            logic [15:0] sum;
            bit          good;
            int          got_done;
            int          e_id, e_mask, e_tag, e_neg;

            good   = (ld % 5) != 3;
            id_b   = 8'(ld * 37 + 16);
            mode_b = (8'(ld * 19) & 8'hF7) | (ld[1] ? 8'h08 : 8'h00);
            tag_b  = (ld == 15) ? 8'd200 : 8'(ld);
            sum    = '0;
            for (int w = 0; w < 63; w++) begin
                mem[w] = 16'(w * 16'h0731 + ld * 16'h1F0B);
                if (w == 32) mem[w] = {mode_b, id_b};
                if (w == 33) mem[w] = {tag_b, 8'h5A};
                sum = sum + mem[w];
            end
            mem[63] = 16'h1234 - sum + (good ? 16'd0 : 16'd1);

            rst = 1'b1;
            repeat (3) @(negedge clk);
            // R1 reset values
            chk("R1 pins", {eep_cs, eep_sk, eep_di}, 0);
            chk("R1 outputs", {own_id, id_mask, act_neg, cfg_valid, load_done}, {3'd7, 8'h80, 3'b000});
            chk("R1 depth", tag_depth, 0);
            rst = 1'b0;
            @(negedge clk);
            chk("R1 pins after release", {eep_cs, eep_sk, eep_di}, 0);

            got_done = 0;
            while (!got_done) begin
                @(negedge clk);
                if (load_done) got_done = 1;
            end

            e_id   = good ? int'(id_b[2:0]) : 7;
            e_mask = 1 << e_id;
            e_tag  = good ? depth_exp(int'(tag_b)) : 0;
            e_neg  = good ? int'(mode_b[3]) : 0;

            chk("R2 frames in order", exp_addr, 64);
            chk("R2 R3 command bits", cmd_err, 0);
            chk("R3 di while sk high", di_err, 0);
            chk("R4 sk high length", sk_err, 0);
            chk("R5 data clocks per frame", frame_err, 0);
            chk("R6 cs gap", gap_err, 0);
            chk("R7 valid", cfg_valid, int'(good));
            if (good) begin
                chk("R8 own id", own_id, e_id);
                chk("R8 id mask", id_mask, e_mask);
                chk("R9 tag depth", tag_depth, e_tag);
                chk("R10 active negation", act_neg, e_neg);
            end else begin
                chk("R11 default id", own_id, e_id);
                chk("R11 default mask", id_mask, e_mask);
                chk("R11 default depth", tag_depth, e_tag);
                chk("R11 default negation", act_neg, e_neg);
            end

            repeat (3 * PHASE) @(negedge clk);
            chk("R12 done pulses", done_cnt, 1);
            chk("R12 pins idle", {eep_cs, eep_sk, eep_di, load_done}, 0);
            chk("R12 outputs held", {own_id, id_mask, act_neg, cfg_valid},
                {3'(e_id), 8'(e_mask), 1'(e_neg), good});
            chk("R12 depth held", tag_depth, e_tag);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule